// File: doc/BRIEF.md
# Sync Reference Validity Monitor

This block sits at the front of a timing generator's lock logic. It watches the horizontal, vertical and frame sync inputs and decides whether the incoming reference can be used for locking. It measures the HSYNC and VSYNC periods in clocks of a free-running reference clock and checks each period against its own legal window. When both periods are legal, the block drops its active-high reference-lost output.

A separate recognizer compares the timing against the table of video formats. It reports its result on `matchValid`/`matchStd`. The monitor turns that result into a six-bit input-standard register, which reads zero whenever the reference is invalid or unrecognized. Once the reference is both valid and recognized, the monitor stops watching VSYNC and FSYNC, so losing them has no effect.

One standard-select code, the manual code (62 by default), changes the rule. In that mode reference-lost simply reports whether HSYNC is present with a short, steady period. The lock-permitted output `lockOk` follows these rules.

Top module: `sync_ref_monitor`

## Requirements
- R1: A rising-edge-to-rising-edge HSYNC period of H_MIN..H_MAX clocks (inclusive) is legal; a shorter or longer period makes the reference invalid.
- R2: A VSYNC period of V_MIN..V_MAX clocks (inclusive) is legal; a shorter or longer period makes the reference invalid.
- R3: FSYNC activity, whether absent, legal or erratic, never changes `refLost`, `lockOk` or `inputStd`.
- R4: When `stdSelect` is not the manual code, `refLost` is 0 exactly when both the HSYNC and VSYNC periods are legal, and 1 otherwise.
- R5: If HSYNC or VSYNC shows no rising edge for more than its upper limit, that input is treated as missing and the reference becomes invalid without waiting for another edge.
- R6: When `stdSelect` equals the manual code, `refLost` is 0 only while HSYNC is stable. Stable means the last two periods differ by at most STAB_TOL clocks and both are below STAB_MAX clocks. Reaching STAB_MAX clocks with no edge clears stability.
- R7: While the reference is valid and recognized, stopping VSYNC and FSYNC leaves `refLost`, `lockOk` and `inputStd` unchanged.
- R8: `inputStd` equals `matchStd` while the reference is valid and `matchValid` is 1; otherwise it is 0.
- R9: `statusWord[0]` equals `refLost`; `statusWord[1]` is 1 while the reference is valid and recognized; `statusWord[2]` reports a legal FSYNC period seen while monitoring; the other bits are 0.
- R10: In non-manual mode, `lockOk` is 0 whenever `refLost` is 1 or the reference is valid but unrecognized. In manual mode, `lockOk` is the inverse of `refLost`.
- R11: During and right after reset, `refLost` is 1, `lockOk` is 0, `inputStd` is 0 and `statusWord` is 1.
- R12: Each sync input passes through a two-flop synchronizer and a rising-edge detector, so one rising edge yields exactly one single-cycle measurement event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsyncIn | input | 1 | Horizontal sync, asynchronous |
| vsyncIn | input | 1 | Vertical sync, asynchronous |
| fsyncIn | input | 1 | Frame sync, asynchronous |
| stdSelect | input | STD_W | Selected output standard code; MANUAL_CODE selects manual mode |
| matchValid | input | 1 | Recognizer reports a matching format |
| matchStd | input | STD_W | Code of the matching format |
| refLost | output | 1 | Reference unusable (active high) |
| lockOk | output | 1 | Locking to the reference is permitted |
| inputStd | output | STD_W | Recognized standard code, 0 when none |
| statusWord | output | STATUS_W | Status register image; bit 0 mirrors refLost |

## Verification
On every cycle, the assertions check these rules: the measurement counters never run past their saturation point, each rising edge yields a single-cycle event, a non-zero `inputStd` only appears with a recognized reference, a frozen VSYNC verdict never drops, manual-mode instability forces reference-lost, and lock is blocked while reference-lost is high outside manual mode. Only the bench scenarios can show the rest. That covers the inclusive window boundaries, detection of a missing sync, FSYNC having no effect, and VSYNC/FSYNC loss being ignored after recognition. It also covers the jitter tolerance in manual mode, which needs whole sync trains with chosen periods.

// File: rtl/syncmon_pkg.sv
package syncmon_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic freeze;       // stop watching VSYNC/FSYNC
  } syncmon_ctrl_t;

  // datapath -> control measurement strobes
  typedef struct packed {
    logic hEdge;
    logic hInWin;
    logic hOver;
    logic stGood;
    logic stBad;
    logic stLost;
    logic vEdge;
    logic vInWin;
    logic vOver;
    logic fEdge;
    logic fInWin;
    logic fOver;
  } syncmon_meas_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/syncmon_edge.sv
module syncmon_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic rise
);
  logic [STAGES-1:0] syncSh;
  logic              prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncSh  <= '0;
      prevLvl <= 1'b0;
    end else begin
      syncSh  <= {syncSh[STAGES-2:0], rawIn};
      prevLvl <= syncSh[STAGES-1];
    end
  end

  assign rise = syncSh[STAGES-1] & ~prevLvl;

  // one edge gives one single-cycle event
  assert_single_rise_R12: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> !rise);

endmodule

// File: rtl/syncmon_meter.sv
module syncmon_meter #(
  parameter int LIMIT = 100,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          en,
  input  logic          edgeIn,
  output logic [CW-1:0] cnt,
  output logic          haveLast
);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      haveLast <= 1'b0;
    end else if (!en) begin
      cnt      <= '0;
      haveLast <= 1'b0;
    end else if (edgeIn) begin
      cnt      <= CW'(1);
      haveLast <= 1'b1;
    end else if (cnt < LIM_V) begin
      cnt <= cnt + 1'b1;
    end else begin
      haveLast <= 1'b0;   // saturated: next edge starts afresh
    end
  end

  assert_cnt_bounded_R5: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LIM_V);

endmodule

// File: rtl/syncmon_datapath.sv
module syncmon_datapath
  import syncmon_pkg::*;
#(
  parameter int H_MIN    = 243,
  parameter int H_MAX    = 1890,
  parameter int V_MIN    = 216000,
  parameter int V_MAX    = 1350000,
  parameter int STAB_MAX = 64800,
  parameter int STAB_TOL = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hsyncIn,
  input  logic          vsyncIn,
  input  logic          fsyncIn,
  input  syncmon_ctrl_t ctrl,
  output syncmon_meas_t meas
);
  localparam int NCH     = 3;
  localparam int H_LIMIT = maxOf(H_MAX, STAB_MAX) + 1;
  localparam int V_LIMIT = V_MAX + 1;
  localparam int CW      = $clog2(maxOf(H_LIMIT, V_LIMIT) + 1);
  localparam logic [CW-1:0] STAB_V = CW'(STAB_MAX);
  localparam logic [CW-1:0] TOL_V  = CW'(STAB_TOL);

  logic [NCH-1:0] rawSync, rise, chEn, haveLast, inWin, over;
  logic [CW-1:0]  cnt [NCH];

  assign rawSync = {fsyncIn, vsyncIn, hsyncIn};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int LIM = (i == 0) ? H_LIMIT : V_LIMIT;
    localparam int LO  = (i == 0) ? H_MIN   : V_MIN;
    localparam int HI  = (i == 0) ? H_MAX   : V_MAX;

    syncmon_edge #(.STAGES(2)) uEdge (
      .clk(clk), .rstN(rstN), .rawIn(rawSync[i]), .rise(rise[i]));

    assign chEn[i] = (i == 0) ? 1'b1 : !ctrl.freeze;

    syncmon_meter #(.LIMIT(LIM), .CW(CW)) uMeter (
      .clk(clk), .rstN(rstN), .en(chEn[i]), .edgeIn(rise[i]),
      .cnt(cnt[i]), .haveLast(haveLast[i]));

    assign inWin[i] = rise[i] && chEn[i] && haveLast[i] &&
                      (cnt[i] >= CW'(LO)) && (cnt[i] <= CW'(HI));
    assign over[i]  = cnt[i] > CW'(HI);
  end

  // HSYNC period history for the manual-mode stability test
  logic [CW-1:0] lastH;
  logic          havePrevH;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastH     <= '0;
      havePrevH <= 1'b0;
    end else if (!haveLast[0]) begin
      havePrevH <= 1'b0;
    end else if (rise[0]) begin
      lastH     <= cnt[0];
      havePrevH <= 1'b1;
    end
  end

  logic [CW-1:0] diffH;
  logic          closeH, shortH, judgeH;

  assign diffH  = (cnt[0] >= lastH) ? (cnt[0] - lastH) : (lastH - cnt[0]);
  assign closeH = diffH <= TOL_V;
  assign shortH = (cnt[0] < STAB_V) && (lastH < STAB_V);
  assign judgeH = rise[0] && haveLast[0] && havePrevH;

  always_comb begin
    meas.hEdge  = rise[0];
    meas.hInWin = inWin[0];
    meas.hOver  = over[0];
    meas.stGood = judgeH && closeH && shortH;
    meas.stBad  = judgeH && !(closeH && shortH);
    meas.stLost = cnt[0] >= STAB_V;
    meas.vEdge  = rise[1] && chEn[1];
    meas.vInWin = inWin[1];
    meas.vOver  = over[1];
    meas.fEdge  = rise[2] && chEn[2];
    meas.fInWin = inWin[2];
    meas.fOver  = over[2];
  end

endmodule

// File: rtl/syncmon_control.sv
module syncmon_control
  import syncmon_pkg::*;
#(
  parameter int STD_W       = 6,
  parameter int MANUAL_CODE = 62
) (
  input  logic             clk,
  input  logic             rstN,
  input  syncmon_meas_t    meas,
  input  logic [STD_W-1:0] stdSelect,
  input  logic             matchValid,
  input  logic [STD_W-1:0] matchStd,
  output syncmon_ctrl_t    ctrl,
  output logic             refLost,
  output logic             lockOk,
  output logic [STD_W-1:0] inputStd,
  output logic             recognized,
  output logic             frameSeen
);
  localparam logic [STD_W-1:0] MANUAL_V = STD_W'(MANUAL_CODE);

  logic hOk, vOk, hStable, manualQ;
  logic manual, refValid, nextLost, nextLock;

  assign manual    = stdSelect == MANUAL_V;
  assign refValid  = hOk && vOk;
  assign nextLost  = manual ? !hStable : !refValid;
  assign nextLock  = manual ? hStable  : (refValid && matchValid);
  assign ctrl.freeze = recognized;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hOk        <= 1'b0;
      vOk        <= 1'b0;
      hStable    <= 1'b0;
      frameSeen  <= 1'b0;
      recognized <= 1'b0;
      inputStd   <= '0;
      refLost    <= 1'b1;
      lockOk     <= 1'b0;
      manualQ    <= 1'b0;
    end else begin
      if (meas.hOver)      hOk <= 1'b0;
      else if (meas.hEdge) hOk <= meas.hInWin;

      if (!ctrl.freeze) begin
        if (meas.vOver)      vOk <= 1'b0;
        else if (meas.vEdge) vOk <= meas.vInWin;
        if (meas.fOver)      frameSeen <= 1'b0;
        else if (meas.fEdge) frameSeen <= meas.fInWin;
      end

      if (meas.stLost)      hStable <= 1'b0;
      else if (meas.stGood) hStable <= 1'b1;
      else if (meas.stBad)  hStable <= 1'b0;

      recognized <= refValid && matchValid;
      inputStd   <= (refValid && matchValid) ? matchStd : '0;
      refLost    <= nextLost;
      lockOk     <= nextLock;
      manualQ    <= manual;
    end
  end

  assert_std_needs_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inputStd != '0) |-> recognized);

  assert_frozen_vsync_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (recognized && vOk) |=> vOk);

  assert_manual_unstable_lost_R6: assert property (@(posedge clk) disable iff (!rstN)
    (manual && !hStable) |=> refLost);

  assert_lock_blocked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!manualQ && refLost) |-> !lockOk);

endmodule

// File: rtl/sync_ref_monitor.sv
module sync_ref_monitor
  import syncmon_pkg::*;
#(
  parameter int H_MIN       = 243,
  parameter int H_MAX       = 1890,
  parameter int V_MIN       = 216000,
  parameter int V_MAX       = 1350000,
  parameter int STAB_MAX    = 64800,
  parameter int STAB_TOL    = 2,
  parameter int STD_W       = 6,
  parameter int MANUAL_CODE = 62,
  parameter int STATUS_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hsyncIn,
  input  logic                vsyncIn,
  input  logic                fsyncIn,
  input  logic [STD_W-1:0]    stdSelect,
  input  logic                matchValid,
  input  logic [STD_W-1:0]    matchStd,
  output logic                refLost,
  output logic                lockOk,
  output logic [STD_W-1:0]    inputStd,
  output logic [STATUS_W-1:0] statusWord
);
  syncmon_ctrl_t ctrl;
  syncmon_meas_t meas;
  logic          recognized, frameSeen;

  syncmon_datapath #(
    .H_MIN(H_MIN), .H_MAX(H_MAX), .V_MIN(V_MIN), .V_MAX(V_MAX),
    .STAB_MAX(STAB_MAX), .STAB_TOL(STAB_TOL)
  ) uDp (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .fsyncIn(fsyncIn), .ctrl(ctrl), .meas(meas));

  syncmon_control #(.STD_W(STD_W), .MANUAL_CODE(MANUAL_CODE)) uCtl (
    .clk(clk), .rstN(rstN), .meas(meas), .stdSelect(stdSelect),
    .matchValid(matchValid), .matchStd(matchStd), .ctrl(ctrl),
    .refLost(refLost), .lockOk(lockOk), .inputStd(inputStd),
    .recognized(recognized), .frameSeen(frameSeen));

  always_comb begin
    statusWord    = '0;
    statusWord[0] = refLost;
    statusWord[1] = recognized;
    statusWord[2] = frameSeen;
  end

endmodule

// File: tb/sync_ref_monitor_test.sv
module sync_ref_monitor_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic       hsyncIn = 1'b0, vsyncIn = 1'b0, fsyncIn = 1'b0;
  logic [5:0] stdSelect = '0, matchStd = '0;
  logic       matchValid = 1'b0;
  logic       refLost, lockOk;
  logic [5:0] inputStd;
  logic [7:0] statusWord;

  sync_ref_monitor #(
    .H_MIN(10), .H_MAX(40), .V_MIN(200), .V_MAX(1000),
    .STAB_MAX(120), .STAB_TOL(2)
  ) uut (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .fsyncIn(fsyncIn), .stdSelect(stdSelect), .matchValid(matchValid),
    .matchStd(matchStd), .refLost(refLost), .lockOk(lockOk),
    .inputStd(inputStd), .statusWord(statusWord));

  int hPer = 0, hJit = 0, vPer = 0, fPer = 0;
  bit hAlt = 1'b0;
  int checks = 0, fails = 0;

  typedef struct {
    string      req;
    logic       lost;
    logic [5:0] std;
    logic       lock;
    logic       rec;
  } exp_t;
  exp_t expQ[$];

  // sync generators: 2-cycle high pulse, period counted rise to rise
  initial forever begin
    if (hPer == 0) @(negedge clk);
    else begin
      hsyncIn = 1'b1; repeat (2) @(negedge clk);
      hsyncIn = 1'b0; repeat (hPer - 2 + (hAlt ? hJit : 0)) @(negedge clk);
      hAlt = !hAlt;
    end
  end
  initial forever begin
    if (vPer == 0) @(negedge clk);
    else begin
      vsyncIn = 1'b1; repeat (2) @(negedge clk);
      vsyncIn = 1'b0; repeat (vPer - 2) @(negedge clk);
    end
  end
  initial forever begin
    if (fPer == 0) @(negedge clk);
    else begin
      fsyncIn = 1'b1; repeat (2) @(negedge clk);
      fsyncIn = 1'b0; repeat (fPer - 2) @(negedge clk);
    end
  end

  function automatic void chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  // monitor: pops expected items and compares the outputs
  initial forever begin
    exp_t e;
    wait (expQ.size() > 0);
    e = expQ.pop_front();
    chk(e.req, "refLost", int'(refLost), int'(e.lost));
    chk(e.req, "inputStd", int'(inputStd), int'(e.std));
    chk(e.req, "lockOk", int'(lockOk), int'(e.lock));
    chk({e.req, " R9"}, "status[0]", int'(statusWord[0]), int'(e.lost));
    chk({e.req, " R9"}, "status[1]", int'(statusWord[1]), int'(e.rec));
  end

  task automatic expectNow(string req, logic lost, logic [5:0] std,
                           logic lock, logic rec);
    exp_t e;
    e.req = req; e.lost = lost; e.std = std; e.lock = lock; e.rec = rec;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  localparam int LONG = 2600;

  initial begin
    settle(4);
    expectNow("R11 in reset", 1, 0, 0, 0);
    rstN = 1'b1;
    settle(1);
    expectNow("R11 after reset", 1, 0, 0, 0);
    checks++;
    if (statusWord[7:2] != 0) begin
      fails++;
      $display("FAIL R11 status upper actual=%0h expected=0", statusWord[7:2]);
    end

    hPer = 20; vPer = 500; fPer = 500; settle(LONG);
    expectNow("R4 R8 R10 valid unrecognized", 0, 0, 0, 0);
    matchStd = 6'd5; matchValid = 1'b1; settle(20);
    expectNow("R8 R10 recognized", 0, 5, 1, 1);
    vPer = 0; fPer = 0; settle(LONG);
    expectNow("R7 vsync/fsync lost while recognized", 0, 5, 1, 1);
    matchValid = 1'b0; settle(20);
    expectNow("R8 unrecognized again", 0, 0, 0, 0);
    settle(1200);
    expectNow("R5 vsync missing", 1, 0, 0, 0);

    vPer = 500; fPer = 7; settle(LONG);
    expectNow("R3 erratic fsync", 0, 0, 0, 0);
    fPer = 0; settle(LONG);
    expectNow("R3 fsync absent", 0, 0, 0, 0);
    hPer = 60; fPer = 500; settle(LONG);
    expectNow("R3 legal fsync bad hsync", 1, 0, 0, 0);

    hPer = 10; vPer = 200; settle(LONG);
    expectNow("R1 R2 lower bounds", 0, 0, 0, 0);
    hPer = 40; vPer = 1000; settle(LONG);
    expectNow("R1 R2 upper bounds", 0, 0, 0, 0);
    hPer = 9; vPer = 500; settle(LONG);
    expectNow("R1 hsync too short", 1, 0, 0, 0);
    hPer = 41; settle(LONG);
    expectNow("R1 hsync too long", 1, 0, 0, 0);
    hPer = 20; vPer = 199; settle(LONG);
    expectNow("R2 vsync too short", 1, 0, 0, 0);
    vPer = 1001; settle(LONG);
    expectNow("R2 vsync too long", 1, 0, 0, 0);

    vPer = 500; settle(LONG);
    expectNow("R4 valid again", 0, 0, 0, 0);
    hPer = 0; settle(100);
    expectNow("R5 hsync missing", 1, 0, 0, 0);

    vPer = 0; fPer = 0; stdSelect = 6'd62; hPer = 100; settle(600);
    expectNow("R6 R10 manual stable", 0, 0, 1, 0);
    hJit = 3; settle(600);
    expectNow("R6 manual jitter 3", 1, 0, 0, 0);
    hJit = 2; settle(600);
    expectNow("R6 manual jitter 2", 0, 0, 1, 0);
    hJit = 0; hPer = 120; settle(600);
    expectNow("R6 manual period at limit", 1, 0, 0, 0);
    hPer = 119; settle(600);
    expectNow("R6 manual period below limit", 0, 0, 1, 0);
    stdSelect = 6'd0; settle(20);
    expectNow("R4 same hsync non-manual", 1, 0, 0, 0);
    stdSelect = 6'd62; settle(600);
    expectNow("R6 manual again", 0, 0, 1, 0);
    hPer = 0; settle(300);
    expectNow("R6 manual hsync gone", 1, 0, 0, 0);

    settle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule